// File: doc/BRIEF.md
# Segmented-Pipeline Transposed FIR Filter

This block is a single-rate FIR filter with fixed coefficients, built in transposed form. Each accepted sample goes to a shared broadcast register that feeds a group of tap multipliers in the same clock. The products are summed along an adder chain, with one register between neighbouring adders. The tap for the oldest coefficient sits at the head of the chain, and the tap for the newest coefficient sits next to the output.

To keep the broadcast fanout bounded as the tap count grows, the taps are split into segments of `SEG` taps. Where one segment ends and the next begins, a single register stage delays both the broadcast sample and the running partial sum. The impulse response is therefore the same as in the unsegmented filter, and the latency rises by one clock per cut.

The coefficients are set at build time through a packed parameter vector. A valid strobe travels alongside the data, so the user sees one valid result for every valid sample, a fixed number of clocks later.

Top module: `fir_seg_transposed`

## Requirements
- R1: For a stream of valid samples x, each valid result equals the full-precision convolution y[n] = sum over k = 0..NTAPS-1 of h[k]*x[n-k]. Coefficient h[k] is the signed CW-bit field at bits [k*CW +: CW] of `COEF_VEC`.
- R2: `out_valid` is high exactly ceil(NTAPS/SEG)+2 clocks after each clock in which `in_valid` was high, and at no other time. `out_data` in that clock carries the result for that sample.
- R3: When SEG >= NTAPS there is no segment cut, and the latency is 3 clocks.
- R4: A single valid sample of value 1, followed by valid zeros, produces results h[0], h[1], ..., h[NTAPS-1] on successive outputs, then zero. The head of the adder chain adds a constant zero.
- R5: While `in_valid` is low, `in_data` is ignored and that clock's sample enters the filter as zero. No `out_valid` is produced for it.
- R6: `out_data` is DW+CW+ceil(log2 NTAPS) bits wide and signed. Results whose magnitude exceeds 2^31 are delivered without truncation or wrap.
- R7: An asynchronous low on `rst_n` clears every register at once, and the clear is released on a clock edge. While held in reset and afterwards, until valid data arrives, `out_valid` is 0 and `out_data` is 0.
- R8: R1 and R2 also hold when NTAPS is not a multiple of SEG (the last segment is short) and when SEG = 1 (a cut between every pair of taps).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Result strobe, delayed by the filter latency |
| out_data | output | DW+CW+ceil(log2 NTAPS) | Signed full-precision result |

## Verification
The bench drives one sample stream into four builds of the block at once, all using the same coefficient set:
- 8 taps in segments of 4 (two segments, latency 4);
- 5 taps with a segment length of 8 (no cut, latency 3);
- 7 taps in segments of 3 (three segments, the last one short);
- 4 taps with a cut after every tap (latency 6).

Between them, these builds cover the unsegmented case, an even split, a short tail segment and the deepest cutting. Impulse, step, sign-aligned extreme samples, gapped random and dense random stimulus are compared against a convolution model. Each result's arrival clock is checked against the latency formula.

// File: rtl/fir_seg_pkg.sv
package fir_seg_pkg;

  // Integer ceiling division used for the segment count.
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  // Extra accumulator bits needed for summing n products.
  function automatic int acc_guard(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/fir_rst_sync.sv
module fir_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_d;
  logic [1:0] sync_q;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/fir_tap.sv
module fir_tap #(
  parameter int               DW   = 16,
  parameter int               CW   = 16,
  parameter int               AW   = 35,
  parameter logic signed [CW-1:0] COEF = '0,
  parameter bit               HEAD = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] x_in,
  input  logic signed [AW-1:0] sum_in,
  output logic signed [AW-1:0] sum_q
);

  localparam int PW = DW + CW;

  logic        [PW-1:0] prod_d;
  logic signed [PW-1:0] prod_q;
  logic signed [AW-1:0] acc_d;

  // Next-state: sign-extended operands, low PW bits of the product are exact.
  always_comb begin
    prod_d = {{CW{x_in[DW-1]}}, x_in} * {{DW{COEF[CW-1]}}, COEF};
    acc_d  = sum_in + {{(AW-PW){prod_q[PW-1]}}, prod_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      sum_q  <= '0;
    end else begin
      prod_q <= prod_d;
      sum_q  <= acc_d;
    end
  end

  // A zero sample must leave a zero product one clock later.
  p_prod_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    x_in == '0 |=> prod_q == '0);

  if (HEAD) begin : g_head_chk
    // Chain head sums against constant zero.
    p_head_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      prod_q == '0 |=> sum_q == '0);
  end

endmodule

// File: rtl/fir_seg_cut.sv
module fir_seg_cut #(
  parameter int DW = 16,
  parameter int AW = 35
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] x_d,
  input  logic signed [AW-1:0] s_d,
  output logic signed [DW-1:0] x_q,
  output logic signed [AW-1:0] s_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      s_q <= '0;
    end else begin
      x_q <= x_d;
      s_q <= s_d;
    end
  end

  // Sample and partial sum cross the cut together.
  p_cut_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (x_d == '0 && s_d == '0) |=> (x_q == '0 && s_q == '0));

endmodule

// File: rtl/fir_seg_transposed.sv
module fir_seg_transposed
  import fir_seg_pkg::*;
#(
  parameter int NTAPS = 8,
  parameter int SEG   = 4,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter logic [NTAPS*CW-1:0] COEF_VEC = {16'h0384, 16'hFFFF, 16'h002D, 16'h8000,
                                             16'h7FFF, 16'h0078, 16'hFFF9, 16'h0003},
  localparam int AW = DW + CW + acc_guard(NTAPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [AW-1:0] out_data
);

  localparam int NSEG = ceil_div(NTAPS, SEG);
  localparam int LAT  = NSEG + 2;

  logic rst_q;

  fir_rst_sync u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_q)
  );

  // Broadcast input register; gaps enter as zero.
  logic signed [DW-1:0] xb_d;
  logic signed [DW-1:0] xb_q;

  always_comb begin
    xb_d = in_valid ? in_data : '0;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      xb_q <= '0;
    end else begin
      xb_q <= xb_d;
    end
  end

  // Segment-level sample and partial-sum nets.
  logic signed [DW-1:0] seg_x    [NSEG];
  logic signed [AW-1:0] cut_s    [NSEG];
  logic signed [AW-1:0] tap_sum  [NTAPS];
  logic signed [AW-1:0] chain_in [NTAPS];

  assign seg_x[0] = xb_q;
  assign cut_s[0] = '0;

  for (genvar g = 1; g < NSEG; g++) begin : g_cut
    fir_seg_cut #(
      .DW (DW),
      .AW (AW)
    ) u_cut (
      .clk   (clk),
      .rst_n (rst_q),
      .x_d   (seg_x[g-1]),
      .s_d   (tap_sum[g*SEG-1]),
      .x_q   (seg_x[g]),
      .s_q   (cut_s[g])
    );
  end

  // Chain position j carries coefficient h[NTAPS-1-j].
  for (genvar j = 0; j < NTAPS; j++) begin : g_tap
    localparam int SIDX = j / SEG;
    localparam logic signed [CW-1:0] HCOEF = COEF_VEC[(NTAPS-1-j)*CW +: CW];

    if (j % SEG == 0) begin : g_seg_head
      assign chain_in[j] = cut_s[SIDX];
    end else begin : g_seg_body
      assign chain_in[j] = tap_sum[j-1];
    end

    fir_tap #(
      .DW   (DW),
      .CW   (CW),
      .AW   (AW),
      .COEF (HCOEF),
      .HEAD (j == 0)
    ) u_tap (
      .clk    (clk),
      .rst_n  (rst_q),
      .x_in   (seg_x[SIDX]),
      .sum_in (chain_in[j]),
      .sum_q  (tap_sum[j])
    );
  end

  assign out_data = tap_sum[NTAPS-1];

  // Valid strobe follows the data path depth.
  logic [LAT-1:0] vpipe_d;
  logic [LAT-1:0] vpipe_q;

  always_comb begin
    vpipe_d = {vpipe_q[LAT-2:0], in_valid};
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      vpipe_q <= '0;
    end else begin
      vpipe_q <= vpipe_d;
    end
  end

  assign out_valid = vpipe_q[LAT-1];

  p_gap_zero_r5: assert property (@(posedge clk) disable iff (!rst_q)
    !$past(in_valid) |-> xb_q == '0);

  p_reset_quiet_r7: assert property (@(posedge clk)
    !rst_q |-> (!out_valid && out_data == '0));

endmodule

// File: tb/fir_seg_transposed_test.sv
module fir_seg_transposed_test;

  localparam logic [127:0] H_ALL = {16'h0384, 16'hFFFF, 16'h002D, 16'h8000,
                                    16'h7FFF, 16'h0078, 16'hFFF9, 16'h0003};
  localparam int LN [4] = '{8, 5, 7, 4};
  localparam int LM [4] = '{4, 8, 3, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic in_valid = 1'b0;
  logic [15:0] in_data = '0;

  always #10 clk = ~clk;

  logic v0, v1, v2, v3;
  logic signed [34:0] y0, y1, y2;
  logic signed [33:0] y3;

  fir_seg_transposed #(.NTAPS(8), .SEG(4), .COEF_VEC(H_ALL)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(v0), .out_data(y0));
  fir_seg_transposed #(.NTAPS(5), .SEG(8), .COEF_VEC(H_ALL[79:0])) uut_flat (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(v1), .out_data(y1));
  fir_seg_transposed #(.NTAPS(7), .SEG(3), .COEF_VEC(H_ALL[111:0])) uut_odd (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(v2), .out_data(y2));
  fir_seg_transposed #(.NTAPS(4), .SEG(1), .COEF_VEC(H_ALL[63:0])) uut_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(v3), .out_data(y3));

  logic   ov [4];
  longint od [4];
  assign ov[0] = v0;  assign od[0] = longint'(y0);
  assign ov[1] = v1;  assign od[1] = longint'(y1);
  assign ov[2] = v2;  assign od[2] = longint'(y2);
  assign ov[3] = v3;  assign od[3] = longint'(y3);

  string lat_tag [4] = '{"R2", "R3", "R8", "R8"};

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit run_mon = 1'b0;
  longint hist [8];

  longint q_exp [4][$];
  int     q_cyc [4][$];
  string  q_tag [4][$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint hk(input int k);
    return longint'($signed(H_ALL[k*16 +: 16]));
  endfunction

  function automatic int lane_lat(input int l);
    return (LN[l] + LM[l] - 1) / LM[l] + 2;
  endfunction

  task automatic drive(input bit v, input logic [15:0] d, input string tag);
    @(negedge clk);
    in_valid = v;
    in_data  = d;
    for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = v ? longint'($signed(d)) : 64'sd0;
    if (v) begin
      for (int l = 0; l < 4; l++) begin
        longint acc;
        acc = 0;
        for (int k = 0; k < LN[l]; k++) acc += hk(k) * hist[k];
        q_exp[l].push_back(acc);
        q_cyc[l].push_back(cyc);
        q_tag[l].push_back(tag);
      end
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (run_mon) begin
      for (int l = 0; l < 4; l++) begin
        if (ov[l]) begin
          if (q_exp[l].size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL %s lane %0d: out_valid with nothing pending, got %0d expected none",
                     lat_tag[l], l, od[l]);
          end else begin
            longint e;
            int c;
            string t;
            e = q_exp[l].pop_front();
            c = q_cyc[l].pop_front();
            t = q_tag[l].pop_front();
            n_cmp++;
            if (od[l] != e) begin
              n_bad++;
              $display("FAIL %s lane %0d: data got %0d expected %0d", t, l, od[l], e);
            end
            n_cmp++;
            if (cyc - c != lane_lat(l)) begin
              n_bad++;
              $display("FAIL %s lane %0d: latency got %0d expected %0d",
                       lat_tag[l], l, cyc - c, lane_lat(l));
            end
          end
        end
      end
    end
  end

  task automatic check_quiet(input string when);
    for (int l = 0; l < 4; l++) begin
      n_cmp++;
      if (ov[l] !== 1'b0 || od[l] != 0) begin
        n_bad++;
        $display("FAIL R7 lane %0d %s: got valid=%b data=%0d expected valid=0 data=0",
                 l, when, ov[l], od[l]);
      end
    end
  endtask

  initial begin
    for (int k = 0; k < 8; k++) hist[k] = 0;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_quiet("in reset");          // R7
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_quiet("after release");     // R7
    run_mon = 1'b1;

    // R4: impulse walks out the coefficients in order
    drive(1'b1, 16'd1, "R4");
    for (int i = 0; i < 10; i++) drive(1'b1, 16'd0, "R4");

    // R1: step response
    for (int i = 0; i < 12; i++) drive(1'b1, 16'd1000, "R1");

    // R6: extreme samples aligned with coefficient signs
    for (int r = 0; r < 2; r++)
      for (int i = 7; i >= 0; i--)
        drive(1'b1, (hk(i) >= 0) ? 16'h7FFF : 16'h8000, "R6");

    // R5: gaps carry garbage data that must be ignored
    for (int i = 0; i < 40; i++)
      drive(($urandom % 3) != 0, 16'($urandom), "R5");

    // R1: dense random stream
    for (int i = 0; i < 60; i++) drive(1'b1, 16'($urandom), "R1");

    // R5: idle drain with garbage on the data pins
    for (int i = 0; i < 12; i++) drive(1'b0, 16'($urandom), "R5");

    // R2: every valid sample produced exactly one result
    for (int l = 0; l < 4; l++) begin
      n_cmp++;
      if (q_exp[l].size() != 0) begin
        n_bad++;
        $display("FAIL R2 lane %0d: pending results got %0d expected 0", l, q_exp[l].size());
      end
    end

    summary();
    $finish;
  end

  initial begin
    #(20 * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    summary();
    $finish;
  end

endmodule